// File: doc/BRIEF.md
# Channel Thermal Protection Gate

This block decides, cycle by cycle, which of eight high-side power channels may actually conduct. It takes the channel pattern last programmed by the host and removes channels that are in thermal protection. It also removes every channel when the output-enable pin has been held low long enough, or while the watchdog reset is active. Comparator flags from the analog sensors arrive as plain logic levels. For each junction there is one flag for above the shutdown threshold and one for below the reset threshold. The case sensor gives the same pair.

A channel that overheats switches off and comes back by itself once its junction has cooled past the hysteresis band. If the case also passes its limit, the channels that were overloaded at that moment are held off until both their junction and the case have cooled. They are then released one at a time, lowest channel number first, with a fixed number of clocks between releases, so that the supply sees no simultaneous inrush. A one-cycle event per channel feeds the host-side fault latch. Two unlatched active-low indicators follow the live fault state: one for channel overtemperature and one for the case warning.

Top module: `thermal_gate`

## Requirements
- R1: After reset `drive`, `ovt_evt` are all 0 and `fault_n`, `twarn_n` are 1.
- R2: When `cmd_load` is high at an edge and the block is ready, the requested pattern becomes `cmd_bits`. Bit i requests channel i. After that edge `drive[i]` equals `cmd_bits[i]` for every channel not in protection.
- R3: A requested, conducting channel whose `tj_hot[i]` is high at an edge stops driving after that edge. `ovt_evt[i]` is high for exactly that one following cycle. An unrequested channel never trips and gives no event.
- R4: A channel tripped by its junction alone stays off while `tj_cool[i]` is low, even with `tj_hot[i]` low. It drives again after the first edge with `tj_cool[i]` high.
- R5: If `tc_hot` is high when a channel trips, or while it is tripped, that channel enters case hold. Channels not overloaded keep driving.
- R6: A channel in case hold leaves it only at an edge where both `tj_cool[i]` and `tc_cool` are high. It then waits for a restart slot.
- R7: Waiting channels are released at most one per `RESTART_GAP` clocks, lowest index first. With two waiting channels the second drives `RESTART_GAP` edges after the first.
- R8: `fault_n` is 0 while any requested channel is tripped or in case hold. It returns to 1 when that channel's request is withdrawn or the channel leaves hold. Waiting channels do not hold it low.
- R9: `twarn_n` goes 0 after an edge with `tc_hot` high and stays 0 until an edge with `tc_cool` high. No latching beyond that.
- R10: `oe_pin` low for `OE_MIN_LOW` consecutive edges clears the requested pattern at the last of them, so all drives go to 0. A shorter low pulse changes nothing.
- R11: After `oe_pin` returns high, loads are ignored for `SETTLE_CYC` edges, counted from the first high sample. The drives stay 0 until the first load after that.
- R12: While `wdog_trip` is high the requested pattern is cleared and loads are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_bits | input | NCH | Requested channel pattern from the command frame |
| cmd_load | input | 1 | One-cycle strobe: new command frame evaluated |
| tj_hot | input | NCH | Per-channel junction above shutdown threshold |
| tj_cool | input | NCH | Per-channel junction below reset threshold |
| tc_hot | input | 1 | Case above its limit |
| tc_cool | input | 1 | Case below its reset threshold |
| oe_pin | input | 1 | Output-enable pin level, active high |
| wdog_trip | input | 1 | Watchdog internal reset active |
| drive | output | NCH | Final per-channel gate enable |
| ovt_evt | output | NCH | One-cycle overtemperature event per channel |
| fault_n | output | 1 | Unlatched channel overtemperature indication, active low |
| twarn_n | output | 1 | Unlatched case warning, active low |

## Verification
The hardest situation to reach is the staggered restart. Two channels must be overloaded at the same edge where the case crosses its limit. Their junctions must then cool while the case stays hot, and the case must next sit inside its hysteresis band before it finally cools. Only then do both channels wait at once. The stimulus walks through exactly that order and checks that the gap elapses and the lower channel goes first. It also checks that a non-overloaded channel kept driving throughout. The output-enable settling boundary is probed by loading on the last ignored edge and again on the first accepted one.

// File: rtl/thgate_pkg.sv
package thgate_pkg;
    typedef enum logic [1:0] {
        CH_RUN   = 2'd0,
        CH_JTRIP = 2'd1,
        CH_CHOLD = 2'd2,
        CH_PEND  = 2'd3
    } ch_state_e;
endpackage

// File: rtl/tg_chan_guard.sv
module tg_chan_guard
    import thgate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic tj_hot,
    input  logic tj_cool,
    input  logic tc_hot,
    input  logic tc_cool,
    input  logic grant,
    output logic run,
    output logic pend,
    output logic tripped,
    output logic evt
);
    typedef struct packed {
        ch_state_e st;
        logic      evt;
    } guard_regs_t;

    guard_regs_t q, d;

    always_comb begin
        d     = q;
        d.evt = 1'b0;
        if (!req) begin
            d.st = CH_RUN;
        end else begin
            unique case (q.st)
                CH_RUN: begin
                    if (tj_hot) begin
                        d.evt = 1'b1;
                        d.st  = tc_hot ? CH_CHOLD : CH_JTRIP;
                    end
                end
                CH_JTRIP: begin
                    if (tc_hot)       d.st = CH_CHOLD;
                    else if (tj_cool) d.st = CH_RUN;
                end
                CH_CHOLD: begin
                    if (tj_cool && tc_cool) d.st = CH_PEND;
                end
                CH_PEND: begin
                    if (grant) d.st = CH_RUN;
                end
                default: d.st = CH_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= CH_RUN;
            q.evt <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign run     = (q.st == CH_RUN);
    assign pend    = req && (q.st == CH_PEND);
    assign tripped = req && ((q.st == CH_JTRIP) || (q.st == CH_CHOLD));
    assign evt     = q.evt;

    // R4: junction-only trip persists until the junction reset flag
    assert_jtrip_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && q.st == CH_JTRIP && !tj_cool && !tc_hot) |=> (q.st == CH_JTRIP))
        else $error("R4 junction trip released early");

    // R6: case hold kept until both junction and case are cool
    assert_case_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && q.st == CH_CHOLD && !(tj_cool && tc_cool)) |=> (q.st == CH_CHOLD))
        else $error("R6 case hold released early");

    // R3: an event is always followed by a non-conducting state
    assert_evt_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.evt |-> (q.st != CH_RUN || !$past(req)))
        else $error("R3 event while still running");
endmodule

// File: rtl/tg_restart_arb.sv
module tg_restart_arb #(
    parameter int NCH = 8,
    parameter int GAP = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pend,
    output logic [NCH-1:0] grant
);
    localparam int GW = (GAP > 1) ? $clog2(GAP) : 1;
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP - 1);

    typedef struct packed {
        logic [GW-1:0] gap;
    } arb_regs_t;

    arb_regs_t q, d;

    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        if (q.gap == '0) begin
            for (int i = 0; i < NCH; i++) begin
                if (pend[i] && !found) begin
                    grant[i] = 1'b1;
                    found    = 1'b1;
                end
            end
        end
        d = q;
        if (found)            d.gap = GAP_LAST;
        else if (q.gap != '0) d.gap = q.gap - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q.gap <= '0;
        else        q <= d;
    end

    // R7: at most one release per slot, only to a waiting channel
    assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant))
        else $error("R7 multiple releases");

    assert_grant_waiting_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~pend) == '0)
        else $error("R7 release to non-waiting channel");

    generate
        if (GAP > 1) begin : g_gap_chk
            assert_grant_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (|grant) |=> !(|grant))
                else $error("R7 back-to-back releases");
        end
    endgenerate
endmodule

// File: rtl/tg_oe_qual.sv
module tg_oe_qual #(
    parameter int MIN_LOW = 200,
    parameter int SETTLE  = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_pin,
    output logic kill,
    output logic ready
);
    localparam int LW = (MIN_LOW > 1) ? $clog2(MIN_LOW) : 1;
    localparam int SW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam logic [LW-1:0] LO_LAST = LW'(MIN_LOW - 1);
    localparam logic [SW-1:0] ST_LAST = SW'(SETTLE - 1);

    typedef struct packed {
        logic [LW-1:0] lo_cnt;
        logic [SW-1:0] st_cnt;
        logic          off;
    } oe_regs_t;

    oe_regs_t q, d;
    logic trip;

    always_comb begin
        trip = !oe_pin && !q.off && (q.lo_cnt == LO_LAST);
        d    = q;
        if (oe_pin)                d.lo_cnt = '0;
        else if (!q.off && !trip)  d.lo_cnt = q.lo_cnt + 1'b1;

        if (trip) begin
            d.off    = 1'b1;
            d.st_cnt = '0;
        end else if (q.off) begin
            if (!oe_pin) begin
                d.st_cnt = '0;
            end else if (q.st_cnt == ST_LAST) begin
                d.off    = 1'b0;
                d.st_cnt = '0;
            end else begin
                d.st_cnt = q.st_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.lo_cnt <= '0;
            q.st_cnt <= '0;
            q.off    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign kill  = trip || q.off;
    assign ready = !q.off;

    // R10: disable only entered while the pin is low
    assert_trip_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.off) |-> $past(!oe_pin))
        else $error("R10 disable without low pin");

    // R11: disable only left after a high sample
    assert_release_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.off) |-> $past(oe_pin))
        else $error("R11 release while pin low");
endmodule

// File: rtl/thermal_gate.sv
module thermal_gate
    import thgate_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int RESTART_GAP = 64,
    parameter int OE_MIN_LOW  = 200,
    parameter int SETTLE_CYC  = 400
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cmd_bits,
    input  logic           cmd_load,
    input  logic [NCH-1:0] tj_hot,
    input  logic [NCH-1:0] tj_cool,
    input  logic           tc_hot,
    input  logic           tc_cool,
    input  logic           oe_pin,
    input  logic           wdog_trip,
    output logic [NCH-1:0] drive,
    output logic [NCH-1:0] ovt_evt,
    output logic           fault_n,
    output logic           twarn_n
);
    typedef struct packed {
        logic [NCH-1:0] req;
        logic           tw;
    } top_regs_t;

    top_regs_t q, d;
    logic oe_kill, oe_ready;
    logic [NCH-1:0] ch_run, ch_pend, ch_trip, ch_grant;

    tg_oe_qual #(
        .MIN_LOW (OE_MIN_LOW),
        .SETTLE  (SETTLE_CYC)
    ) u_oe (
        .clk    (clk),
        .rst_n  (rst_n),
        .oe_pin (oe_pin),
        .kill   (oe_kill),
        .ready  (oe_ready)
    );

    tg_restart_arb #(
        .NCH (NCH),
        .GAP (RESTART_GAP)
    ) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (ch_pend),
        .grant (ch_grant)
    );

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            tg_chan_guard u_guard (
                .clk     (clk),
                .rst_n   (rst_n),
                .req     (q.req[i]),
                .tj_hot  (tj_hot[i]),
                .tj_cool (tj_cool[i]),
                .tc_hot  (tc_hot),
                .tc_cool (tc_cool),
                .grant   (ch_grant[i]),
                .run     (ch_run[i]),
                .pend    (ch_pend[i]),
                .tripped (ch_trip[i]),
                .evt     (ovt_evt[i])
            );
        end
    endgenerate

    always_comb begin
        d = q;
        if (oe_kill || wdog_trip)       d.req = '0;
        else if (cmd_load && oe_ready)  d.req = cmd_bits;
        if (tc_hot)       d.tw = 1'b1;
        else if (tc_cool) d.tw = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.req <= '0;
            q.tw  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign drive   = q.req & ch_run;
    assign fault_n = ~(|ch_trip);
    assign twarn_n = ~q.tw;

    // R9: case over limit pulls the warning low on the next cycle
    assert_twarn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tc_hot |=> !twarn_n)
        else $error("R9 warning not asserted");

    // R12: watchdog reset leaves every channel off
    assert_wdog_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_trip |=> (drive == '0))
        else $error("R12 drive during watchdog reset");

    // R10: qualified disable leaves every channel off
    assert_oe_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_kill |=> (drive == '0))
        else $error("R10 drive while disabled");
endmodule

// File: tb/thermal_gate_bench.sv
`timescale 1ns/100ps
module thermal_gate_bench;
    localparam int NCH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] cmd_bits = '0;
    logic cmd_load = 1'b0;
    logic [NCH-1:0] tj_hot = '0;
    logic [NCH-1:0] tj_cool = '1;
    logic tc_hot = 1'b0;
    logic tc_cool = 1'b1;
    logic oe_pin = 1'b1;
    logic wdog_trip = 1'b0;
    logic [NCH-1:0] drive, ovt_evt;
    logic fault_n, twarn_n;

    always #2.5 clk = ~clk;

    thermal_gate #(
        .NCH (NCH), .RESTART_GAP (4), .OE_MIN_LOW (3), .SETTLE_CYC (5)
    ) u_thermal_gate (
        .clk (clk), .rst_n (rst_n), .cmd_bits (cmd_bits), .cmd_load (cmd_load),
        .tj_hot (tj_hot), .tj_cool (tj_cool), .tc_hot (tc_hot), .tc_cool (tc_cool),
        .oe_pin (oe_pin), .wdog_trip (wdog_trip), .drive (drive),
        .ovt_evt (ovt_evt), .fault_n (fault_n), .twarn_n (twarn_n)
    );

    typedef struct {
        string          tag;
        logic [NCH-1:0] drv;
        logic [NCH-1:0] evt;
        logic           fn;
        logic           twn;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // monitor: compares queued expectations mid-cycle
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (drive !== e.drv || ovt_evt !== e.evt || fault_n !== e.fn || twarn_n !== e.twn) begin
                errors++;
                $display("FAIL %s: actual drive=%h evt=%h fault_n=%b twarn_n=%b expected drive=%h evt=%h fault_n=%b twarn_n=%b",
                         e.tag, drive, ovt_evt, fault_n, twarn_n, e.drv, e.evt, e.fn, e.twn);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string tag, input logic [NCH-1:0] drv,
                              input logic [NCH-1:0] evt, input logic fn, input logic twn);
        exp_t e;
        e.tag = tag; e.drv = drv; e.evt = evt; e.fn = fn; e.twn = twn;
        sb.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic load(input logic [NCH-1:0] v);
        cmd_bits = v;
        cmd_load = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        expect_out("R1 reset state", 8'h00, 8'h00, 1'b1, 1'b1);

        // R2 load
        load(8'hA5); step(); cmd_load = 1'b0;
        expect_out("R2 load A5", 8'hA5, 8'h00, 1'b1, 1'b1);

        // R3 junction trip on channel 0
        tj_hot = 8'h01; tj_cool = 8'hFE; step();
        expect_out("R3 trip off + event", 8'hA4, 8'h01, 1'b0, 1'b1);
        step();
        expect_out("R3 event single cycle", 8'hA4, 8'h00, 1'b0, 1'b1);

        // R4 hysteresis then auto restart
        tj_hot = 8'h00; step();
        expect_out("R4 still off in band", 8'hA4, 8'h00, 1'b0, 1'b1);
        tj_cool = 8'hFF; step();
        expect_out("R4 auto restart", 8'hA5, 8'h00, 1'b1, 1'b1);

        // R3 unrequested channel does not trip
        tj_hot = 8'h02; tj_cool = 8'hFD; step();
        expect_out("R3 unrequested no trip", 8'hA5, 8'h00, 1'b1, 1'b1);
        tj_hot = 8'h00; tj_cool = 8'hFF;

        // R5 case shutdown of overloaded channels 0 and 2
        tj_hot = 8'h05; tj_cool = 8'hFA; tc_hot = 1'b1; tc_cool = 1'b0; step();
        expect_out("R5 only overloaded off", 8'hA0, 8'h05, 1'b0, 1'b0);
        tj_hot = 8'h00; tj_cool = 8'hFF; step();
        expect_out("R6 hold with hot case", 8'hA0, 8'h00, 1'b0, 1'b0);
        tc_hot = 1'b0; step();
        expect_out("R9 warning kept in band", 8'hA0, 8'h00, 1'b0, 1'b0);
        tc_cool = 1'b1; step();
        expect_out("R8 waiting releases fault", 8'hA0, 8'h00, 1'b1, 1'b1);
        step();
        expect_out("R7 lowest first", 8'hA1, 8'h00, 1'b1, 1'b1);
        for (int k = 0; k < 3; k++) begin
            step();
            expect_out("R7 gap holds second", 8'hA1, 8'h00, 1'b1, 1'b1);
        end
        step();
        expect_out("R7 second after gap", 8'hA5, 8'h00, 1'b1, 1'b1);

        // R8 fault released by withdrawing request
        tj_hot = 8'h01; tj_cool = 8'hFE; step();
        expect_out("R8 fault low on trip", 8'hA4, 8'h01, 1'b0, 1'b1);
        load(8'hA4); step(); cmd_load = 1'b0;
        expect_out("R8 fault released by cmd off", 8'hA4, 8'h00, 1'b1, 1'b1);
        tj_hot = 8'h00; tj_cool = 8'hFF;
        load(8'hA5); step(); cmd_load = 1'b0;
        expect_out("R2 reload A5", 8'hA5, 8'h00, 1'b1, 1'b1);

        // R10 short low pulse ignored
        oe_pin = 1'b0; step();
        expect_out("R10 short pulse 1", 8'hA5, 8'h00, 1'b1, 1'b1);
        step();
        expect_out("R10 short pulse 2", 8'hA5, 8'h00, 1'b1, 1'b1);
        oe_pin = 1'b1; step();
        expect_out("R10 short pulse ignored", 8'hA5, 8'h00, 1'b1, 1'b1);

        // R10 qualified low disables
        oe_pin = 1'b0; step();
        expect_out("R10 low 1", 8'hA5, 8'h00, 1'b1, 1'b1);
        step();
        expect_out("R10 low 2", 8'hA5, 8'h00, 1'b1, 1'b1);
        step();
        expect_out("R10 disabled at min low", 8'h00, 8'h00, 1'b1, 1'b1);
        load(8'h5A); step(); cmd_load = 1'b0;
        expect_out("R10 load ignored while low", 8'h00, 8'h00, 1'b1, 1'b1);

        // R11 settling
        oe_pin = 1'b1; load(8'h5A); step(); cmd_load = 1'b0;
        expect_out("R11 load ignored settle 1", 8'h00, 8'h00, 1'b1, 1'b1);
        for (int k = 0; k < 3; k++) begin
            step();
            expect_out("R11 stays off without cmd", 8'h00, 8'h00, 1'b1, 1'b1);
        end
        load(8'h5A); step(); cmd_load = 1'b0;
        expect_out("R11 load ignored last settle edge", 8'h00, 8'h00, 1'b1, 1'b1);
        load(8'h5A); step(); cmd_load = 1'b0;
        expect_out("R11 load accepted after settle", 8'h5A, 8'h00, 1'b1, 1'b1);

        // R12 watchdog
        wdog_trip = 1'b1; step();
        expect_out("R12 watchdog clears", 8'h00, 8'h00, 1'b1, 1'b1);
        load(8'hFF); step(); cmd_load = 1'b0;
        expect_out("R12 load ignored in watchdog", 8'h00, 8'h00, 1'b1, 1'b1);
        wdog_trip = 1'b0; load(8'hFF); step(); cmd_load = 1'b0;
        expect_out("R12 load after watchdog", 8'hFF, 8'h00, 1'b1, 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule